// File: doc/BRIEF.md
# Voice Segment Pointer Manager

This block keeps the bookkeeping for a message recorder that stores a list of numbered voice segments. It holds the number of stored segments and a current-segment pointer, and it updates both from single-cycle action strobes that an upstream key decoder produces. The actions are: request and finish a recording, erase the current segment, move forward or backward (short or long press), skip during playback, return the pointer to the first segment, and wipe the whole store. The pointer and count are registered and appear at the ports one clock after the strobe.

A new recording is inserted directly after the current segment and becomes the current segment. Every later segment therefore shifts up by one, and only the count and the pointer reflect that. Erasing removes the current segment and steps the pointer back. A recording request is rejected when the store is at its segment limit or the memory reports full. A rejection raises a one-cycle invalid pulse and starts a timed blink on the status LED. The blink is paced by a tick-enable input. The LED is otherwise lit steadily while a recording or an erase/format job is in progress. A mode input selects single-segment operation, in which one segment at most exists and skip requests a stop instead of moving.

Top module: `seg_ptr_mgr`

## Requirements
- R1: After reset (active-low `rst_n`) the pointer and count are 0 and `led`, `invalid` and `stop_req` are 0.
- R2: After an accepted `rec_req`, a `rec_done` strobe inserts a segment after the pointer: one clock later the count is one higher and the pointer is one higher. A `rec_done` with no accepted request has no effect.
- R3: A `rec_req` is rejected when the count equals the limit (63 in multi mode, 1 when `single_mode`=1) or `mem_full`=1. A rejection gives `invalid`=1 for exactly the cycle after the strobe and leaves the count unchanged.
- R4: A rejection lights `led` at once. `led` then toggles on each `tick` for 12 ticks (6 Hz ticks give a 3 Hz blink over 2 s) and the blink ends after the 12th tick. A new rejection restarts the 12-tick window with `led`=1.
- R5: When no blink is active, `led` is 1 from an accepted `rec_req` until `rec_done`, and it is 1 while `fmt_busy`=1. Otherwise `led` is 0.
- R6: `erase` with a nonzero count lowers the count by one. The pointer becomes pointer-1 when the pointer exceeds 1. When the pointer is 1 it stays 1 if segments remain and becomes 0 if none remain. With a count of 0, `erase` has no effect. The pointer is 0 exactly when the count is 0.
- R7: `fwd_short` moves the pointer up by one unless it already equals the count. `fwd_long` sets the pointer to the count.
- R8: `bwd_short` moves the pointer down by one unless it is 1 or 0. `bwd_long` sets the pointer to 1 when the count is nonzero.
- R9: In multi mode with a nonzero count, `skip` advances the pointer and wraps from the last segment to 1. In single mode, `skip` leaves the pointer unchanged and gives `stop_req`=1 for the next cycle.
- R10: `ptr_reset` sets the pointer to 1, or to 0 when the count is 0. `chip_erase` sets the count and pointer to 0 and cancels a recording in progress. When strobes coincide, the priority is `chip_erase`, then `ptr_reset`, `rec_done`, `erase`, `skip`, `fwd_long`, `fwd_short`, `bwd_long`, `bwd_short`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| single_mode | input | 1 | 1 selects single-segment operation |
| mem_full | input | 1 | Storage has no room for another recording |
| tick | input | 1 | Blink pacing enable, one cycle per half blink period |
| fmt_busy | input | 1 | An erase or format job is running |
| rec_req | input | 1 | Recording request strobe |
| rec_done | input | 1 | Recording finished strobe |
| erase | input | 1 | Erase current segment strobe |
| fwd_short | input | 1 | Move to next segment strobe |
| fwd_long | input | 1 | Move to last segment strobe |
| bwd_short | input | 1 | Move to previous segment strobe |
| bwd_long | input | 1 | Move to first segment strobe |
| skip | input | 1 | Skip strobe during playback |
| ptr_reset | input | 1 | Pointer back to first segment strobe |
| chip_erase | input | 1 | Wipe all segments strobe |
| cap | output | 6 | Current segment pointer, 0 when empty |
| seg_count | output | 6 | Number of stored segments |
| invalid | output | 1 | One-cycle pulse on a rejected request |
| stop_req | output | 1 | One-cycle stop request from skip in single mode |
| led | output | 1 | Status LED drive |

## Verification
The pointer and count are the block's whole state and are driven straight from registers. A wrong update therefore appears on `cap` or `seg_count` one clock after the offending strobe, and the bench compares both after every action. A rejection decision that is wrong shows as a missing or extra `invalid` pulse in that same cycle. A blink counter that is wrong shows only in tick units, as an LED phase that is off or a window that ends early or late. For that reason the LED is sampled after individual ticks and across a restarted window.

// File: rtl/seg_ptr_mgr.sv
module seg_ptr_mgr #(
  parameter int MAX_SEG     = 63,
  parameter int BLINK_TICKS = 12,
  localparam int SW = $clog2(MAX_SEG + 1),
  localparam int BW = $clog2(BLINK_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single_mode,
  input  logic          mem_full,
  input  logic          tick,
  input  logic          fmt_busy,
  input  logic          rec_req,
  input  logic          rec_done,
  input  logic          erase,
  input  logic          fwd_short,
  input  logic          fwd_long,
  input  logic          bwd_short,
  input  logic          bwd_long,
  input  logic          skip,
  input  logic          ptr_reset,
  input  logic          chip_erase,
  output logic [SW-1:0] cap,
  output logic [SW-1:0] seg_count,
  output logic          invalid,
  output logic          stop_req,
  output logic          led
);

  logic [SW-1:0] cap_q, cnt_q, cap_d, cnt_d;
  logic          rec_q, inv_q, stop_q, phase_q;
  logic [BW-1:0] blink_q;

  wire [SW-1:0] limit    = single_mode ? SW'(1) : SW'(MAX_SEG);
  wire          full_w   = mem_full || (cnt_q >= limit);
  wire          reject_w = rec_req && !rec_q && full_w;
  wire          accept_w = rec_req && !rec_q && !full_w;
  wire          has_seg  = cnt_q != '0;
  wire          at_last  = cap_q == cnt_q;
  wire          blinking = blink_q != '0;

  always_comb begin
    cap_d = cap_q;
    cnt_d = cnt_q;
    if (chip_erase) begin
      cap_d = '0;
      cnt_d = '0;
    end else if (ptr_reset) begin
      cap_d = has_seg ? SW'(1) : '0;
    end else if (rec_done && rec_q) begin
      cnt_d = cnt_q + SW'(1);
      cap_d = cap_q + SW'(1);
    end else if (erase && has_seg) begin
      cnt_d = cnt_q - SW'(1);
      if (cap_q > SW'(1)) cap_d = cap_q - SW'(1);
      else                cap_d = (cnt_q > SW'(1)) ? SW'(1) : '0;
    end else if (skip && !single_mode && has_seg) begin
      cap_d = at_last ? SW'(1) : cap_q + SW'(1);
    end else if (fwd_long) begin
      cap_d = cnt_q;
    end else if (fwd_short && !at_last) begin
      cap_d = cap_q + SW'(1);
    end else if (bwd_long) begin
      cap_d = has_seg ? SW'(1) : '0;
    end else if (bwd_short && cap_q > SW'(1)) begin
      cap_d = cap_q - SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      cnt_q   <= '0;
      rec_q   <= 1'b0;
      inv_q   <= 1'b0;
      stop_q  <= 1'b0;
      phase_q <= 1'b0;
      blink_q <= '0;
    end else begin
      cap_q  <= cap_d;
      cnt_q  <= cnt_d;
      inv_q  <= reject_w;
      stop_q <= skip && single_mode;
      if (chip_erase)    rec_q <= 1'b0;
      else if (accept_w) rec_q <= 1'b1;
      else if (rec_done) rec_q <= 1'b0;
      if (reject_w) begin
        blink_q <= BW'(BLINK_TICKS);
        phase_q <= 1'b1;
      end else if (tick && blinking) begin
        blink_q <= blink_q - BW'(1);
        phase_q <= !phase_q;
      end
    end
  end

  assign cap       = cap_q;
  assign seg_count = cnt_q;
  assign invalid   = inv_q;
  assign stop_req  = stop_q;
  assign led       = blinking ? phase_q : (rec_q || fmt_busy);

  AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> cnt_q == '0 && cap_q == '0); // R1
  AST_INSERT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done && rec_q && !chip_erase && !ptr_reset
    |=> cnt_q == $past(cnt_q) + SW'(1) && cap_q == $past(cap_q) + SW'(1)); // R2
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= SW'(MAX_SEG)); // R3
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reject_w && !erase && !chip_erase |=> inv_q && cnt_q == $past(cnt_q)); // R3
  AST_BLINK_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
    blinking && tick && !reject_w |=> blink_q == $past(blink_q) - BW'(1)); // R4
  AST_BUSY_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !blinking && fmt_busy |-> led); // R5
  AST_ZERO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) == (cap_q == '0)); // R6
  AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cap_q <= cnt_q); // R7
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    skip && single_mode && !chip_erase && !ptr_reset && !rec_done && !erase
    && !fwd_long && !fwd_short && !bwd_long && !bwd_short
    |=> cap_q == $past(cap_q) && stop_q); // R9

endmodule

// File: tb/seg_ptr_mgr_tb_top.sv
module seg_ptr_mgr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic single_mode = 0, mem_full = 0, tick = 0, fmt_busy = 0;
  logic rec_req = 0, rec_done = 0, erase = 0, fwd_short = 0, fwd_long = 0;
  logic bwd_short = 0, bwd_long = 0, skip = 0, ptr_reset = 0, chip_erase = 0;
  logic [5:0] cap, seg_count;
  logic invalid, stop_req, led;
  int checks = 0;
  int errors = 0;

  localparam int K_REQ = 0, K_DONE = 1, K_ERASE = 2, K_FS = 3, K_FL = 4, K_BS = 5,
                 K_BL = 6, K_SKIP = 7, K_PRST = 8, K_CHIP = 9, K_TICK = 10;

  always #2.5 clk = !clk;

  seg_ptr_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .single_mode(single_mode), .mem_full(mem_full),
    .tick(tick), .fmt_busy(fmt_busy), .rec_req(rec_req), .rec_done(rec_done),
    .erase(erase), .fwd_short(fwd_short), .fwd_long(fwd_long),
    .bwd_short(bwd_short), .bwd_long(bwd_long), .skip(skip),
    .ptr_reset(ptr_reset), .chip_erase(chip_erase), .cap(cap),
    .seg_count(seg_count), .invalid(invalid), .stop_req(stop_req), .led(led)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_k(input int k, input logic v);
    case (k)
      K_REQ:   rec_req = v;
      K_DONE:  rec_done = v;
      K_ERASE: erase = v;
      K_FS:    fwd_short = v;
      K_FL:    fwd_long = v;
      K_BS:    bwd_short = v;
      K_BL:    bwd_long = v;
      K_SKIP:  skip = v;
      K_PRST:  ptr_reset = v;
      K_CHIP:  chip_erase = v;
      default: tick = v;
    endcase
  endtask

  task automatic hit(input int k);
    @(negedge clk); set_k(k, 1'b1);
    @(negedge clk); set_k(k, 1'b0);
  endtask

  task automatic record_one();
    hit(K_REQ);
    hit(K_DONE);
  endtask

  task automatic drain_blink();
    for (int i = 0; i < 12; i++) hit(K_TICK);
  endtask

  task automatic t_reset();
    chk("R1 cap", cap, 0);
    chk("R1 count", seg_count, 0);
    chk("R1 led", led, 0);
    chk("R1 invalid", invalid, 0);
    chk("R1 stop_req", stop_req, 0);
  endtask

  task automatic t_insert();
    hit(K_DONE);
    chk("R2 done without request count", seg_count, 0);
    for (int i = 1; i <= 5; i++) begin
      record_one();
      chk("R2 append cap", cap, i);
    end
    chk("R2 count after five", seg_count, 5);
    hit(K_BS); hit(K_BS);
    chk("R8 back twice", cap, 3);
    record_one();
    chk("R2 insert count", seg_count, 6);
    chk("R2 insert cap", cap, 4);
  endtask

  task automatic t_nav();
    hit(K_FS);
    chk("R7 next", cap, 5);
    hit(K_FL);
    chk("R7 to last", cap, 6);
    hit(K_FS);
    chk("R7 next at last holds", cap, 6);
    hit(K_BL);
    chk("R8 to first", cap, 1);
    hit(K_BS);
    chk("R8 previous at first holds", cap, 1);
  endtask

  task automatic t_skip();
    hit(K_FL);
    hit(K_SKIP);
    chk("R9 skip wraps", cap, 1);
    hit(K_SKIP);
    chk("R9 skip advances", cap, 2);
    chk("R9 no stop in multi", stop_req, 0);
  endtask

  task automatic t_erase();
    hit(K_ERASE);
    chk("R6 erase count", seg_count, 5);
    chk("R6 erase cap back", cap, 1);
    hit(K_ERASE);
    chk("R6 erase at first count", seg_count, 4);
    chk("R6 erase at first cap", cap, 1);
    for (int i = 0; i < 4; i++) hit(K_ERASE);
    chk("R6 emptied count", seg_count, 0);
    chk("R6 emptied cap", cap, 0);
    hit(K_ERASE);
    chk("R6 erase empty count", seg_count, 0);
    chk("R6 erase empty cap", cap, 0);
  endtask

  task automatic t_busy_led();
    @(negedge clk); fmt_busy = 1'b1;
    @(negedge clk);
    chk("R5 format busy led", led, 1);
    fmt_busy = 1'b0;
    @(negedge clk);
    chk("R5 idle led", led, 0);
    hit(K_REQ);
    chk("R5 recording led", led, 1);
    hit(K_DONE);
    chk("R5 led after done", led, 0);
    chk("R2 first record cap", cap, 1);
  endtask

  task automatic t_limit();
    hit(K_CHIP);
    for (int i = 0; i < 63; i++) record_one();
    chk("R3 full count", seg_count, 63);
    chk("R3 full cap", cap, 63);
    hit(K_REQ);
    chk("R3 reject pulse", invalid, 1);
    chk("R3 count unchanged", seg_count, 63);
    chk("R4 led on at reject", led, 1);
    @(negedge clk);
    chk("R3 pulse one cycle", invalid, 0);
    hit(K_TICK);
    chk("R4 first tick off", led, 0);
    hit(K_TICK);
    chk("R4 second tick on", led, 1);
    for (int i = 0; i < 3; i++) hit(K_TICK);
    hit(K_REQ);
    chk("R4 restart led on", led, 1);
    for (int i = 0; i < 10; i++) hit(K_TICK);
    chk("R4 restarted window alive", led, 1);
    hit(K_TICK);
    chk("R4 eleventh tick phase", led, 0);
    hit(K_TICK);
    chk("R4 window ended", led, 0);
    hit(K_TICK);
    chk("R4 stays off", led, 0);
  endtask

  task automatic t_memfull();
    hit(K_CHIP);
    record_one();
    @(negedge clk); mem_full = 1'b1;
    hit(K_REQ);
    chk("R3 memory full reject", invalid, 1);
    chk("R3 memory full count", seg_count, 1);
    mem_full = 1'b0;
    drain_blink();
    chk("R5 no recording after reject", led, 0);
  endtask

  task automatic t_single();
    hit(K_CHIP);
    @(negedge clk); single_mode = 1'b1;
    record_one();
    chk("R2 single first record", seg_count, 1);
    hit(K_REQ);
    chk("R3 single limit reject", invalid, 1);
    chk("R3 single count", seg_count, 1);
    drain_blink();
    hit(K_SKIP);
    chk("R9 single skip stop", stop_req, 1);
    chk("R9 single skip cap", cap, 1);
    hit(K_CHIP);
    single_mode = 1'b0;
  endtask

  task automatic t_ptr_reset();
    for (int i = 0; i < 3; i++) record_one();
    chk("R10 setup cap", cap, 3);
    hit(K_PRST);
    chk("R10 pointer to first", cap, 1);
    chk("R10 count kept", seg_count, 3);
    hit(K_REQ);
    hit(K_CHIP);
    chk("R10 chip erase count", seg_count, 0);
    chk("R10 chip erase cap", cap, 0);
    chk("R10 recording cancelled", led, 0);
    hit(K_DONE);
    chk("R10 done after cancel", seg_count, 0);
    hit(K_PRST);
    chk("R10 pointer reset empty", cap, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_insert();
    t_nav();
    t_skip();
    t_erase();
    t_busy_led();
    t_limit();
    t_memfull();
    t_single();
    t_ptr_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule